// File: doc/BRIEF.md
# Front Panel Memory Entry Controller

This block is the hardwired console logic that lets an operator load and inspect memory by hand, with no monitor program running. It takes clean one-cycle key events from sixteen hexadecimal keys and from five function keys: clear, address mode, data mode, examine and deposit. It holds a 16-bit address register and an 8-bit data register. Both registers are always visible on the address and data lamp outputs.

The block drives a simple synchronous memory port. A deposit writes the data register to the current address and then steps the address forward, so consecutive bytes can be keyed in one after another. An examine reads the current address and places the returned byte in the data register.

The block acts only while the processor reports that it is halted. It does not control running or stepping of the processor, key debouncing, or lamp drivers.

Top module: `fp_entry_ctrl`

## Requirements
- R1: After reset the address register is 0x0000, the data register is 0x00, address-entry mode is selected, and neither memory strobe is active.
- R2: A pulse on key_addr_mode selects address-entry mode. In this mode each hex_strobe shifts the address register left by 4 bits and places hex_value in bits [3:0]. All 16 bits are kept.
- R3: A pulse on key_data_mode selects data-entry mode. In this mode each hex_strobe shifts the data register left by 4 bits and places hex_value in bits [3:0]. Only the low 8 bits are kept.
- R4: key_clear sets the register of the current entry mode to zero and leaves the other register unchanged.
- R5: key_deposit raises mem_we for exactly one cycle, in the cycle after the key, with mem_addr equal to the address register and mem_wdata equal to the data register. From the following cycle the address register is one higher.
- R6: A deposit at address 0xFFFF leaves the address register at 0x0000.
- R7: Hex entries into the data register without a deposit never produce a write. The last digits typed replace the pending byte.
- R8: key_examine raises mem_re for exactly one cycle, in the cycle after the key, with mem_addr equal to the address register. The memory returns the byte on mem_rdata in the next cycle, and the data register holds that byte from the cycle after that. The address is unchanged.
- R9: While cpu_halted is low, every key is ignored: no register changes and no memory strobe.
- R10: A key that arrives while a memory access is in progress is ignored. This covers the one strobe cycle after a deposit, and the strobe and return cycles after an examine.
- R11: When several keys arrive in the same cycle, only the one with the highest priority acts. The order is: clear, address mode, data mode, examine, deposit, hex.
- R12: led_addr always equals the address register and led_data always equals the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_halted | input | 1 | High while the processor is halted; enables the panel |
| key_clear | input | 1 | One-cycle clear key event |
| key_addr_mode | input | 1 | One-cycle address-mode key event |
| key_data_mode | input | 1 | One-cycle data-mode key event |
| key_examine | input | 1 | One-cycle examine key event |
| key_deposit | input | 1 | One-cycle deposit key event |
| hex_strobe | input | 1 | One-cycle hex key event |
| hex_value | input | 4 | Digit of the hex key pressed |
| mem_addr | output | 16 | Memory address, equal to the address register |
| mem_wdata | output | 8 | Memory write data, equal to the data register |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| led_addr | output | 16 | Address lamps |
| led_data | output | 8 | Data lamps |

## Verification
Two pairs of functions can land in the same clock cycle.

The first pair is a new key and a memory access still in progress. The bench places a hex key in the strobe cycle right after a deposit, and in both busy cycles after an examine. It then judges from the lamps that the address advanced or the read byte arrived, and that the digit left no trace.

The second pair is two keys pressed in the same cycle. The bench drives deposit together with a hex digit, and address mode together with data mode. It checks that only the higher-priority key took effect, by looking at the written memory and at where the following digit lands.

// File: rtl/fp_pkg.sv
// Package: shared types for the front panel entry controller.
// Assumes: one decoded command per cycle at most.
package fp_pkg;

    // Which register the hex keys feed
    typedef enum logic {
        MODE_ADDR = 1'b0,
        MODE_DATA = 1'b1
    } entry_mode_t;

    // Command chosen by the key arbiter in one cycle
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_CLR  = 3'd1,
        CMD_ADR  = 3'd2,
        CMD_DAT  = 3'd3,
        CMD_EXAM = 3'd4,
        CMD_DEP  = 3'd5,
        CMD_HEX  = 3'd6
    } panel_cmd_t;

    // Memory access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_CAP  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/fp_key_arbiter.sv
// Module: fp_key_arbiter
// Picks at most one command from the key events of a cycle, by fixed priority.
// Assumes: key events are clean one-cycle pulses. The arbiter itself is
// combinational. Keys are dropped when the CPU runs or the sequencer is busy.
module fp_key_arbiter
    import fp_pkg::*;
(
    input  logic       cpu_halted,
    input  logic       busy,
    input  logic       key_clear,
    input  logic       key_addr_mode,
    input  logic       key_data_mode,
    input  logic       key_examine,
    input  logic       key_deposit,
    input  logic       hex_strobe,
    output panel_cmd_t cmd
);

    // Priority select: clear, address, data, examine, deposit, hex
    always_comb begin
        cmd = CMD_NONE;
        if (cpu_halted && !busy) begin
            if (key_clear)          cmd = CMD_CLR;
            else if (key_addr_mode) cmd = CMD_ADR;
            else if (key_data_mode) cmd = CMD_DAT;
            else if (key_examine)   cmd = CMD_EXAM;
            else if (key_deposit)   cmd = CMD_DEP;
            else if (hex_strobe)    cmd = CMD_HEX;
        end
    end

endmodule

// File: rtl/fp_mem_seq.sv
// Module: fp_mem_seq
// Runs the memory cycles: a one-cycle write for deposit, and a one-cycle read
// followed by a capture cycle for examine.
// Assumes: the memory returns read data one cycle after the read strobe.
module fp_mem_seq
    import fp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  panel_cmd_t cmd,
    output logic       busy,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic       rd_load,
    output logic       addr_inc
);

    seq_state_t state_q;

    // State register: leave idle on deposit or examine, always return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd == CMD_DEP)       state_q <= ST_WR;
                    else if (cmd == CMD_EXAM) state_q <= ST_RD;
                end
                ST_WR:   state_q <= ST_IDLE;
                ST_RD:   state_q <= ST_CAP;
                ST_CAP:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes and register controls decoded from the state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        wr_stb   = (state_q == ST_WR);
        rd_stb   = (state_q == ST_RD);
        rd_load  = (state_q == ST_CAP);
        addr_inc = (state_q == ST_WR);
    end

endmodule

// File: rtl/fp_entry_regs.sv
// Module: fp_entry_regs
// Holds the address register, the data register and the entry mode. Applies
// hex shifts, clears, mode changes, the address step and read data loads.
// Assumes: addr_inc and rd_load occur only in cycles where cmd is CMD_NONE.
module fp_entry_regs
    import fp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  panel_cmd_t        cmd,
    input  logic [NIB_W-1:0]  hex_value,
    input  logic              addr_inc,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int ADDR_KEEP = ADDR_W - NIB_W;
    localparam int DATA_KEEP = DATA_W - NIB_W;

    entry_mode_t mode_q;
    logic [ADDR_W-1:0] addr_shifted;
    logic [DATA_W-1:0] data_shifted;

    // Shifted candidates: drop the top nibble, insert the new digit at the bottom
    always_comb begin
        addr_shifted = {addr_q[ADDR_KEEP-1:0], hex_value};
        data_shifted = {data_q[DATA_KEEP-1:0], hex_value};
    end

    // Register update for commands, address step and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mode_q <= MODE_ADDR;
        end else begin
            if (addr_inc) addr_q <= addr_q + 1'b1;
            if (rd_load)  data_q <= rd_data;
            unique case (cmd)
                CMD_CLR: begin
                    if (mode_q == MODE_ADDR) addr_q <= '0;
                    else                     data_q <= '0;
                end
                CMD_ADR: mode_q <= MODE_ADDR;
                CMD_DAT: mode_q <= MODE_DATA;
                CMD_HEX: begin
                    if (mode_q == MODE_ADDR) addr_q <= addr_shifted;
                    else                     data_q <= data_shifted;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fp_entry_ctrl.sv
// Module: fp_entry_ctrl (top)
// Front panel memory entry controller. It arbitrates key events, keeps the
// address and data registers, drives the lamps, and runs the deposit and
// examine cycles on a synchronous memory port.
// Assumes: clean one-cycle key pulses and a memory with one cycle of read latency.
module fp_entry_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_halted,
    input  logic              key_clear,
    input  logic              key_addr_mode,
    input  logic              key_data_mode,
    input  logic              key_examine,
    input  logic              key_deposit,
    input  logic              hex_strobe,
    input  logic [3:0]        hex_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] led_addr,
    output logic [DATA_W-1:0] led_data
);

    import fp_pkg::*;

    localparam int NIB_W = 4;

    panel_cmd_t        cmd;
    logic              busy;
    logic              rd_load;
    logic              addr_inc;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    fp_key_arbiter u_arb (
        .cpu_halted    (cpu_halted),
        .busy          (busy),
        .key_clear     (key_clear),
        .key_addr_mode (key_addr_mode),
        .key_data_mode (key_data_mode),
        .key_examine   (key_examine),
        .key_deposit   (key_deposit),
        .hex_strobe    (hex_strobe),
        .cmd           (cmd)
    );

    fp_mem_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .busy     (busy),
        .wr_stb   (mem_we),
        .rd_stb   (mem_re),
        .rd_load  (rd_load),
        .addr_inc (addr_inc)
    );

    fp_entry_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .hex_value (hex_value),
        .addr_inc  (addr_inc),
        .rd_load   (rd_load),
        .rd_data   (mem_rdata),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    // Memory port and lamps follow the registers directly
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = data_q;
        led_addr  = addr_q;
        led_data  = data_q;
    end

endmodule

// File: rtl/fp_entry_chk.sv
// Module: fp_entry_chk
// Port-level timing checks for fp_entry_ctrl, attached by bind.
// Assumes: synchronous active-low reset; memory read latency of one cycle.
module fp_entry_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_halted,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] led_addr,
    input logic [DATA_W-1:0] led_data
);

    // R5
    wr_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && (led_addr == ADDR_W'($past(mem_addr) + 1'b1))));

    // R6
    wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_addr == {ADDR_W{1'b1}})) |=> (led_addr == '0));

    // R8
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we));

    // R8
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ##1 (led_data == $past(mem_rdata)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R9
    run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halted && !mem_we && !mem_re && !$past(mem_re))
        |=> ($stable(led_addr) && $stable(led_data) && !mem_we && !mem_re));

endmodule

bind fp_entry_ctrl fp_entry_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_halted (cpu_halted),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .led_addr   (led_addr),
    .led_data   (led_data)
);

// File: tb/fp_entry_ctrl_test.sv
`timescale 1ns/1ps
// Bench for fp_entry_ctrl. Sweeps key entry, deposit and examine patterns
// against a bench memory model. Expected values are computed arithmetically.
module fp_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_halted = 1'b1;
    logic        key_clear = 1'b0;
    logic        key_addr_mode = 1'b0;
    logic        key_data_mode = 1'b0;
    logic        key_examine = 1'b0;
    logic        key_deposit = 1'b0;
    logic        hex_strobe = 1'b0;
    logic [3:0]  hex_value = 4'h0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] led_addr;
    logic [7:0]  led_data;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    bit done = 0;
    logic [15:0] last_waddr = 16'h0;
    logic [7:0]  last_wdata = 8'h0;
    logic [7:0]  bmem [0:255];

    // 200 MHz clock
    always #2.5 clk = ~clk;

    fp_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted),
        .key_clear(key_clear), .key_addr_mode(key_addr_mode),
        .key_data_mode(key_data_mode), .key_examine(key_examine),
        .key_deposit(key_deposit), .hex_strobe(hex_strobe),
        .hex_value(hex_value), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .led_addr(led_addr), .led_data(led_data)
    );

    // Bench memory: indexed by the low address byte, one cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
            last_waddr <= mem_addr;
            last_wdata <= mem_wdata;
            wr_count = wr_count + 1;
        end
        if (mem_re) begin
            mem_rdata <= bmem[mem_addr[7:0]];
            rd_count = rd_count + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic release_keys();
        key_clear = 0; key_addr_mode = 0; key_data_mode = 0;
        key_examine = 0; key_deposit = 0; hex_strobe = 0;
    endtask

    // One key event (bit order: clear, addr, data, examine, deposit, hex), then settle
    task automatic press(input logic [5:0] k, input logic [3:0] d);
        @(negedge clk);
        key_clear = k[5]; key_addr_mode = k[4]; key_data_mode = k[3];
        key_examine = k[2]; key_deposit = k[1]; hex_strobe = k[0];
        hex_value = d;
        @(negedge clk);
        release_keys();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_addr(input logic [15:0] a);
        press(6'b010000, 4'h0);
        for (int i = 3; i >= 0; i--) press(6'b000001, a[i*4 +: 4]);
    endtask

    task automatic set_data(input logic [7:0] d);
        press(6'b001000, 4'h0);
        press(6'b000001, d[7:4]);
        press(6'b000001, d[3:0]);
    endtask

    initial begin
        int w0;
        int r0;
        logic [15:0] a;
        logic [7:0]  d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 led_addr", {16'h0, led_addr}, 32'h0);
        check("R1 led_data", {24'h0, led_data}, 32'h0);
        check("R1 strobes", {30'h0, mem_we, mem_re}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default mode is address entry
        press(6'b000001, 4'hC);
        check("R1 default addr mode", {16'h0, led_addr}, 32'h000C);

        // R2 / R12 address entry sweep
        for (int v = 0; v < 256; v++) begin
            a = {v[3:0], v[7:4], ~v[3:0], v[7:4] ^ v[3:0]};
            set_addr(a);
            check("R2 R12 address entry", {16'h0, led_addr}, {16'h0, a});
        end
        // R2: a fifth digit drops the top nibble
        press(6'b000001, 4'h7);
        check("R2 shift out", {16'h0, led_addr}, {16'h0, a[11:0], 4'h7});

        // R3 / R7 data entry sweep with no writes
        w0 = wr_count;
        for (int v = 0; v < 256; v++) begin
            set_data(v[7:0]);
            check("R3 R12 data entry", {24'h0, led_data}, v);
        end
        press(6'b000001, 4'h9);
        check("R3 shift out", {24'h0, led_data}, 32'h000000F9);
        check("R7 no write on retype", wr_count, w0);

        // R4 clear acts on the selected register only
        set_addr(16'h1234); set_data(8'h56);
        press(6'b100000, 4'h0);
        check("R4 clear data", {24'h0, led_data}, 32'h0);
        check("R4 addr kept", {16'h0, led_addr}, 32'h1234);
        set_data(8'h56);
        press(6'b010000, 4'h0);
        press(6'b100000, 4'h0);
        check("R4 clear addr", {16'h0, led_addr}, 32'h0);
        check("R4 data kept", {24'h0, led_data}, 32'h56);

        // R5 consecutive deposits
        set_addr(16'hFC00);
        press(6'b001000, 4'h0);
        for (int i = 0; i < 64; i++) begin
            d = 8'((i * 37 + 5) & 8'hFF);
            press(6'b000001, d[7:4]);
            press(6'b000001, d[3:0]);
            w0 = wr_count;
            press(6'b000010, 4'h0);
            check("R5 one write", wr_count - w0, 1);
            check("R5 write addr", {16'h0, last_waddr}, 32'hFC00 + i);
            check("R5 write data", {24'h0, last_wdata}, {24'h0, d});
            check("R5 addr step", {16'h0, led_addr}, 32'hFC01 + i);
        end

        // R8 examine back each byte
        for (int i = 0; i < 64; i++) begin
            set_addr(16'hFC00 + 16'(i));
            set_data(8'hEE);
            r0 = rd_count;
            press(6'b000100, 4'h0);
            check("R8 one read", rd_count - r0, 1);
            check("R8 read data", {24'h0, led_data}, (i * 37 + 5) & 8'hFF);
            check("R8 addr kept", {16'h0, led_addr}, 32'hFC00 + i);
        end

        // R6 wrap
        set_addr(16'hFFFF); set_data(8'hA5);
        press(6'b000010, 4'h0);
        check("R6 wrap", {16'h0, led_addr}, 32'h0);
        check("R6 write addr", {16'h0, last_waddr}, 32'hFFFF);

        // R9 keys ignored while CPU runs
        set_addr(16'h0040); set_data(8'h3C);
        cpu_halted = 1'b0;
        w0 = wr_count; r0 = rd_count;
        press(6'b000001, 4'h1);
        press(6'b100000, 4'h0);
        press(6'b010000, 4'h0);
        press(6'b000001, 4'h2);
        press(6'b000010, 4'h0);
        press(6'b000100, 4'h0);
        check("R9 addr", {16'h0, led_addr}, 32'h0040);
        check("R9 data", {24'h0, led_data}, 32'h3C);
        check("R9 no access", (wr_count - w0) + (rd_count - r0), 0);
        cpu_halted = 1'b1;
        // R9: the data mode was kept, so a hex digit goes to data
        press(6'b000001, 4'h7);
        check("R9 mode kept", {24'h0, led_data}, 32'hC7);

        // R10 hex key in the strobe cycle after a deposit
        set_addr(16'h0080); set_data(8'h11);
        @(negedge clk); key_deposit = 1;
        @(negedge clk); key_deposit = 0; hex_strobe = 1; hex_value = 4'hA;
        @(negedge clk); release_keys();
        repeat (3) @(negedge clk);
        check("R10 data after deposit", {24'h0, led_data}, 32'h11);
        check("R10 addr after deposit", {16'h0, led_addr}, 32'h0081);
        // R10 hex keys in both busy cycles after an examine
        set_addr(16'h0080); set_data(8'h99);
        @(negedge clk); key_examine = 1;
        @(negedge clk); key_examine = 0; hex_strobe = 1; hex_value = 4'h3;
        @(negedge clk); hex_value = 4'h4;
        @(negedge clk); release_keys();
        repeat (3) @(negedge clk);
        check("R10 data after examine", {24'h0, led_data}, 32'h11);

        // R11 deposit and hex in the same cycle: deposit wins
        set_addr(16'h00C0); set_data(8'h42);
        w0 = wr_count;
        press(6'b000011, 4'hF);
        check("R11 deposit wins write", wr_count - w0, 1);
        check("R11 deposit wins data", {24'h0, last_wdata}, 32'h42);
        check("R11 hex dropped", {24'h0, led_data}, 32'h42);
        // R11 address and data modes together: address wins
        press(6'b011000, 4'h0);
        press(6'b000001, 4'h5);
        check("R11 addr mode wins", {16'h0, led_addr}, 32'h0C15);
        check("R11 data untouched", {24'h0, led_data}, 32'h42);
        // R11 clear and deposit together: clear wins, no write
        w0 = wr_count;
        press(6'b100010, 4'h0);
        check("R11 clear wins", {16'h0, led_addr}, 32'h0);
        check("R11 no write", wr_count - w0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule